// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

This block moves bytes inside a linear framebuffer on behalf of software. Software programs a handful of 32-bit registers (source corner, destination corner, rectangle size, fill colour, row pitches and a framebuffer base), then writes a control word whose top bit launches the operation. The engine either paints every byte of the destination rectangle with one colour, or copies a source rectangle onto a destination rectangle, and holds a busy flag until the last byte is written.

The framebuffer is reached through a plain synchronous byte port: one request per cycle, and read data returns on the cycle after a read request. A copy alternates a read cycle and a write cycle per byte. When the two rectangles overlap, software asks for reverse traversal and supplies the bottom-right corners, so the engine walks each row right to left and the rows bottom to top, and no source byte is overwritten before it has been read.

The controller is a five-state machine. IDLE waits for the launch bit; on launch it goes to FILL (fill command), READ (copy command), or straight to FINISH (empty rectangle or unknown command). FILL writes one byte per cycle and stays there until the last byte, then goes to FINISH. READ always goes to WRITE; WRITE returns to READ, or to FINISH after the last byte. FINISH clears the launch bit and returns to IDLE.

Top module: `blit_engine`

## Requirements
- R1: Registers sit at word offsets 0 source corner, 1 destination corner, 2 size, 3 control, 4 fill colour, 5 pitch, 6 base, 7 status; offsets 0 to 6 read back what was written, the base register keeping only ADDR_W bits. Corners pack x in bits 31:16 and y in bits 15:0; size packs the width in bytes in bits 31:16 and the height in rows in bits 15:0; pitch packs the destination pitch in bits 31:16 and the source pitch in bits 15:0.
- R2: The byte address of point (x, y) is base + y × pitch + x, using the destination pitch for destination bytes and the source pitch for source bytes.
- R3: Writing the control word with bit 31 set while idle launches an operation; from the next cycle the busy port, status bit 3 and control bit 31 read 1 until completion, when bit 31 clears and the other control bits keep the written value.
- R4: Command code 1 in control bits 19:16 fills the destination rectangle with the low byte of the fill colour register, one byte written per cycle.
- R5: Command code 0 copies the source rectangle to the destination rectangle: every read request is followed in the next cycle by the write of the returned byte.
- R6: Control bit 27 selects reverse traversal: the corner registers hold bottom-right corners (x+w−1, y+h−1), x decreases along a row and y decreases between rows; with bit 27 clear the first byte written is the top-left corner.
- R7: When software sets bit 27 exactly when the source row is above the destination row, or on the same row and left of it, an overlapping copy leaves the destination equal to the source as it was before the operation.
- R8: A control-word write while busy has no effect: the running operation is not restarted or changed and the control register reads its earlier value.
- R9: A launch with zero width, zero height, or a command code other than 0 or 1 completes without any memory request.
- R10: No byte outside the destination rectangle is written.
- R11: After reset every register reads 0, busy is low and no memory request is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Framebuffer access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Framebuffer byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid the cycle after a read request |

## Verification
On every cycle the assertions check that a read is always followed by a write, that the byte counters are never zero while the machine is active, that the machine is never active without the launch bit, that the launch bit falls only on completion, that a control write while busy leaves the configuration unchanged, and that memory stays silent while idle. Only the bench's scenarios show that the right bytes land at the right addresses: fill sweeps over many sizes in both directions, copy sweeps over every nearby overlap offset compared against a snapshot of the source, distinct source and destination pitches, the starting corner of each traversal, and the empty and unknown-command launches.

// File: rtl/blit_pkg.sv
package blit_pkg;

    localparam int COORD_W = 16;

    // register word offsets
    localparam logic [2:0] OFS_SRC   = 3'd0;
    localparam logic [2:0] OFS_DST   = 3'd1;
    localparam logic [2:0] OFS_SIZE  = 3'd2;
    localparam logic [2:0] OFS_CTRL  = 3'd3;
    localparam logic [2:0] OFS_COLOR = 3'd4;
    localparam logic [2:0] OFS_PITCH = 3'd5;
    localparam logic [2:0] OFS_BASE  = 3'd6;
    localparam logic [2:0] OFS_STAT  = 3'd7;

    // control word fields
    localparam int CTRL_GO_BIT  = 31;
    localparam int CTRL_REV_BIT = 27;
    localparam int CMD_LSB      = 16;
    localparam int CMD_W        = 4;
    localparam int STAT_BUSY_BIT = 3;

    localparam logic [CMD_W-1:0] CMD_COPY = 4'h0;
    localparam logic [CMD_W-1:0] CMD_FILL = 4'h1;

    typedef struct packed {
        logic [COORD_W-1:0] x;
        logic [COORD_W-1:0] y;
    } point_t;

    typedef struct packed {
        logic [COORD_W-1:0] w;
        logic [COORD_W-1:0] h;
    } extent_t;

    typedef struct packed {
        logic [COORD_W-1:0] dst;
        logic [COORD_W-1:0] src;
    } stride_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_READ,
        ST_WRITE,
        ST_FINISH
    } eng_state_e;

endpackage

// File: rtl/blit_addr.sv
module blit_addr #(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0]          base,
    input  logic [blit_pkg::COORD_W-1:0] pitch,
    input  logic [blit_pkg::COORD_W-1:0] x,
    input  logic [blit_pkg::COORD_W-1:0] y,
    output logic [ADDR_W-1:0]          addr
);
    localparam int PROD_W = 2 * blit_pkg::COORD_W;
    localparam int SUM_W  = PROD_W + 2;

    logic [PROD_W-1:0] row_off;
    logic [SUM_W-1:0]  total;

    assign row_off = {{blit_pkg::COORD_W{1'b0}}, y} * {{blit_pkg::COORD_W{1'b0}}, pitch};
    assign total   = SUM_W'(base) + SUM_W'(row_off) + SUM_W'(x);
    assign addr    = total[ADDR_W-1:0];
endmodule

// File: rtl/blit_regs.sv
module blit_regs
    import blit_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [2:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               done,
    output logic               go,
    output logic [CMD_W-1:0]   cmd,
    output logic               rev,
    output point_t             src_pt,
    output point_t             dst_pt,
    output extent_t            size,
    output stride_t            pitch,
    output logic [ADDR_W-1:0]  base,
    output logic [7:0]         color_byte
);
    logic [31:0]       src_q, dst_q, size_q, ctrl_q, color_q, pitch_q;
    logic [ADDR_W-1:0] base_q;
    logic              wr_ctrl;

    assign go      = ctrl_q[CTRL_GO_BIT];
    assign wr_ctrl = reg_we && (reg_addr == OFS_CTRL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q   <= '0;
            dst_q   <= '0;
            size_q  <= '0;
            ctrl_q  <= '0;
            color_q <= '0;
            pitch_q <= '0;
            base_q  <= '0;
        end else begin
            if (done) begin
                ctrl_q[CTRL_GO_BIT] <= 1'b0;
            end
            if (reg_we) begin
                unique case (reg_addr)
                    OFS_SRC:   src_q   <= reg_wdata;
                    OFS_DST:   dst_q   <= reg_wdata;
                    OFS_SIZE:  size_q  <= reg_wdata;
                    OFS_CTRL:  if (!go) ctrl_q <= reg_wdata;
                    OFS_COLOR: color_q <= reg_wdata;
                    OFS_PITCH: pitch_q <= reg_wdata;
                    OFS_BASE:  base_q  <= reg_wdata[ADDR_W-1:0];
                    OFS_STAT:  ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_SRC:   reg_rdata = src_q;
            OFS_DST:   reg_rdata = dst_q;
            OFS_SIZE:  reg_rdata = size_q;
            OFS_CTRL:  reg_rdata = ctrl_q;
            OFS_COLOR: reg_rdata = color_q;
            OFS_PITCH: reg_rdata = pitch_q;
            OFS_BASE:  reg_rdata = 32'(base_q);
            OFS_STAT:  reg_rdata = 32'(go) << STAT_BUSY_BIT;
        endcase
    end

    assign cmd        = ctrl_q[CMD_LSB +: CMD_W];
    assign rev        = ctrl_q[CTRL_REV_BIT];
    assign src_pt     = point_t'(src_q);
    assign dst_pt     = point_t'(dst_q);
    assign size       = extent_t'(size_q);
    assign pitch      = stride_t'(pitch_q);
    assign base       = base_q;
    assign color_byte = color_q[7:0];

    // R8: a control write during an operation leaves the configuration as it was
    assert_busy_ctrl_write_ignored_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        (go && wr_ctrl) |=> (ctrl_q[30:0] == $past(ctrl_q[30:0]))
    );

    // R3: the launch bit only falls when the sequencer reports completion
    assert_go_falls_on_done_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        $fell(go) |-> $past(done)
    );
endmodule

// File: rtl/blit_seq.sv
module blit_seq
    import blit_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [CMD_W-1:0]   cmd,
    input  logic               rev,
    input  point_t             src_pt,
    input  point_t             dst_pt,
    input  extent_t            size,
    input  stride_t            pitch,
    input  logic [ADDR_W-1:0]  base,
    input  logic [7:0]         color_byte,
    input  logic [7:0]         mem_rdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [7:0]         mem_wdata,
    output logic               done
);
    eng_state_e state_q, state_d;

    // latched operands
    point_t             src_start_q, dst_start_q;
    point_t             src_cur_q, dst_cur_q;
    logic [COORD_W-1:0] width_q;
    logic [COORD_W-1:0] col_left_q, row_left_q;
    stride_t            pitch_q;
    logic [ADDR_W-1:0]  base_q;
    logic [7:0]         color_q;
    logic               rev_q;

    logic               empty_rect, known_cmd, last_byte, advance;
    logic [ADDR_W-1:0]  src_addr, dst_addr;

    assign empty_rect = (size.w == '0) || (size.h == '0);
    assign known_cmd  = (cmd == CMD_FILL) || (cmd == CMD_COPY);
    assign last_byte  = (col_left_q == COORD_W'(1)) && (row_left_q == COORD_W'(1));
    assign advance    = (state_q == ST_FILL) || (state_q == ST_WRITE);

    blit_addr #(.ADDR_W(ADDR_W)) u_src_addr (
        .base (base_q),
        .pitch(pitch_q.src),
        .x    (src_cur_q.x),
        .y    (src_cur_q.y),
        .addr (src_addr)
    );

    blit_addr #(.ADDR_W(ADDR_W)) u_dst_addr (
        .base (base_q),
        .pitch(pitch_q.dst),
        .x    (dst_cur_q.x),
        .y    (dst_cur_q.y),
        .addr (dst_addr)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go) begin
                    if (empty_rect || !known_cmd) state_d = ST_FINISH;
                    else if (cmd == CMD_FILL)     state_d = ST_FILL;
                    else                          state_d = ST_READ;
                end
            end
            ST_FILL:   if (last_byte) state_d = ST_FINISH;
            ST_READ:   state_d = ST_WRITE;
            ST_WRITE:  state_d = last_byte ? ST_FINISH : ST_READ;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // walking datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_start_q <= '0;
            dst_start_q <= '0;
            src_cur_q   <= '0;
            dst_cur_q   <= '0;
            width_q     <= '0;
            col_left_q  <= '0;
            row_left_q  <= '0;
            pitch_q     <= '0;
            base_q      <= '0;
            color_q     <= '0;
            rev_q       <= 1'b0;
        end else if ((state_q == ST_IDLE) && go) begin
            src_start_q <= src_pt;
            dst_start_q <= dst_pt;
            src_cur_q   <= src_pt;
            dst_cur_q   <= dst_pt;
            width_q     <= size.w;
            col_left_q  <= size.w;
            row_left_q  <= size.h;
            pitch_q     <= pitch;
            base_q      <= base;
            color_q     <= color_byte;
            rev_q       <= rev;
        end else if (advance && !last_byte) begin
            if (col_left_q == COORD_W'(1)) begin
                col_left_q    <= width_q;
                row_left_q    <= row_left_q - COORD_W'(1);
                src_cur_q.x   <= src_start_q.x;
                dst_cur_q.x   <= dst_start_q.x;
                src_cur_q.y   <= rev_q ? src_cur_q.y - COORD_W'(1) : src_cur_q.y + COORD_W'(1);
                dst_cur_q.y   <= rev_q ? dst_cur_q.y - COORD_W'(1) : dst_cur_q.y + COORD_W'(1);
            end else begin
                col_left_q    <= col_left_q - COORD_W'(1);
                src_cur_q.x   <= rev_q ? src_cur_q.x - COORD_W'(1) : src_cur_q.x + COORD_W'(1);
                dst_cur_q.x   <= rev_q ? dst_cur_q.x - COORD_W'(1) : dst_cur_q.x + COORD_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = dst_addr;
        mem_wdata = color_q;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_FILL: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = color_q;
            end
            ST_READ: begin
                mem_req  = 1'b1;
                mem_addr = src_addr;
            end
            ST_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = mem_rdata;
            end
            ST_FINISH: done = 1'b1;
            default: ;
        endcase
    end

    // R5: each source read is followed by the destination write
    assert_read_then_write_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> (mem_req && mem_we)
    );

    // R4: byte counters never run dry while bytes are being moved
    assert_counters_live_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        ((state_q == ST_FILL) || (state_q == ST_READ) || (state_q == ST_WRITE))
            |-> ((col_left_q != '0) && (row_left_q != '0))
    );

    // R3: the machine is only away from idle while the launch bit is held
    assert_active_needs_go_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> go
    );
endmodule

// File: rtl/blit_engine.sv
module blit_engine
    import blit_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);
    logic              go, done, rev;
    logic [CMD_W-1:0]  cmd;
    point_t            src_pt, dst_pt;
    extent_t           size;
    stride_t           pitch;
    logic [ADDR_W-1:0] base;
    logic [7:0]        color_byte;

    blit_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .done      (done),
        .go        (go),
        .cmd       (cmd),
        .rev       (rev),
        .src_pt    (src_pt),
        .dst_pt    (dst_pt),
        .size      (size),
        .pitch     (pitch),
        .base      (base),
        .color_byte(color_byte)
    );

    blit_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .cmd       (cmd),
        .rev       (rev),
        .src_pt    (src_pt),
        .dst_pt    (dst_pt),
        .size      (size),
        .pitch     (pitch),
        .base      (base),
        .color_byte(color_byte),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .done      (done)
    );

    assign busy = go;

    // R11: memory port stays silent whenever no operation is running
    assert_idle_no_access_R11: assert property (
        @(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req
    );
endmodule

// File: tb/blit_engine_tb.sv
module blit_engine_tb;
    localparam int AW    = 10;
    localparam int MEMSZ = 1 << AW;
    localparam int BASE  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          busy;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    rdata_q = '0;

    logic [7:0]    mem  [0:MEMSZ-1];
    logic [7:0]    expm [0:MEMSZ-1];
    logic [7:0]    snap [0:MEMSZ-1];
    logic [AW-1:0] wr_log [0:255];
    int            nwr = 0, nrd = 0;
    int            checks = 0, fails = 0;

    always #4 clk = ~clk;

    blit_engine #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(rdata_q)
    );

    always @(posedge clk) begin
        if (mem_req && mem_we) begin
            mem[mem_addr] <= mem_wdata;
            wr_log[nwr[7:0]] <= mem_addr;
            nwr <= nwr + 1;
        end
        if (mem_req && !mem_we) begin
            rdata_q <= mem[mem_addr];
            nrd <= nrd + 1;
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails = fails + 1;
        $display("FAIL watchdog: actual hung expected completion");
        summary();
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic int fa(input int p, input int x, input int y);
        return (BASE + y * p + x) % MEMSZ;
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 4000 && busy; i++) @(negedge clk);
    endtask

    task automatic check_mem(input string req);
        int bad = 0, first = -1;
        for (int i = 0; i < MEMSZ; i++) begin
            if (mem[i] !== expm[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        if (bad == 0) chk(1'b1, req, "memory", 0, 0);
        else chk(1'b0, req, $sformatf("memory byte %0h", first), int'(mem[first]), int'(expm[first]));
    endtask

    function automatic logic [31:0] ctl(input int cmd, input bit rev);
        return (32'h1 << 31) | (32'(rev) << 27) | (32'(cmd & 15) << 16) | 32'h0000A5C3;
    endfunction

    task automatic do_fill(input int x, input int y, input int w, input int h, input bit rev, input logic [7:0] col);
        int w0 = nwr;
        int cx = rev ? x + w - 1 : x;
        int cy = rev ? y + h - 1 : y;
        wr(3'd4, {24'hABCDEF, col});
        wr(3'd1, {16'(cx), 16'(cy)});
        wr(3'd2, {16'(w), 16'(h)});
        wr(3'd3, ctl(1, rev));
        wait_idle();
        for (int r = 0; r < h; r++)
            for (int c = 0; c < w; c++)
                expm[fa(32, x + c, y + r)] = col;
        check_mem(rev ? "R6 R10 reverse fill" : "R4 R10 fill");
        chk((nwr - w0) == w * h, "R4", "write count", nwr - w0, w * h);
        chk(int'(wr_log[w0[7:0]]) == fa(32, cx, cy), "R6", "first write address",
            int'(wr_log[w0[7:0]]), fa(32, cx, cy));
    endtask

    task automatic do_copy(input int sx, input int sy, input int dx, input int dy,
                           input int w, input int h, input int sp, input int dp, input string req);
        int w0 = nwr, r0 = nrd;
        bit rev = (sy < dy) || ((sy == dy) && (sx < dx));
        int o = rev ? 1 : 0;
        for (int i = 0; i < MEMSZ; i++) snap[i] = expm[i];
        wr(3'd5, {16'(dp), 16'(sp)});
        wr(3'd0, {16'(sx + o * (w - 1)), 16'(sy + o * (h - 1))});
        wr(3'd1, {16'(dx + o * (w - 1)), 16'(dy + o * (h - 1))});
        wr(3'd2, {16'(w), 16'(h)});
        wr(3'd3, ctl(0, rev));
        wait_idle();
        for (int r = 0; r < h; r++)
            for (int c = 0; c < w; c++)
                expm[fa(dp, dx + c, dy + r)] = snap[fa(sp, sx + c, sy + r)];
        check_mem(req);
        chk((nwr - w0) == w * h && (nrd - r0) == w * h, "R5", "read/write counts",
            (nrd - r0) * 65536 + (nwr - w0), w * h * 65537);
        chk(int'(wr_log[w0[7:0]]) == fa(dp, dx + o * (w - 1), dy + o * (h - 1)), "R6",
            "copy first write", int'(wr_log[w0[7:0]]), fa(dp, dx + o * (w - 1), dy + o * (h - 1)));
    endtask

    initial begin
        logic [31:0] v;
        int w0, r0;
        for (int i = 0; i < MEMSZ; i++) begin
            mem[i]  = 8'((i * 7 + 3) ^ (i >> 3));
            expm[i] = 8'((i * 7 + 3) ^ (i >> 3));
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk(v == 32'h0, "R11", $sformatf("register %0d after reset", a), int'(v), 0);
        end
        chk(busy == 1'b0 && nwr == 0 && nrd == 0, "R11", "idle after reset", int'(busy), 0);

        // R1 register readback
        wr(3'd0, 32'h1234_5678); rd(3'd0, v); chk(v == 32'h1234_5678, "R1", "source", int'(v), 32'h12345678);
        wr(3'd1, 32'h9ABC_DEF0); rd(3'd1, v); chk(v == 32'h9ABC_DEF0, "R1", "dest", int'(v), 32'h9ABCDEF0);
        wr(3'd2, 32'h0000_0000); rd(3'd2, v); chk(v == 32'h0, "R1", "size", int'(v), 0);
        wr(3'd4, 32'hCAFE_F00D); rd(3'd4, v); chk(v == 32'hCAFE_F00D, "R1", "colour", int'(v), 32'hCAFEF00D);
        wr(3'd5, 32'h0020_0018); rd(3'd5, v); chk(v == 32'h0020_0018, "R1", "pitch", int'(v), 32'h00200018);
        wr(3'd6, 32'h0001_2345); rd(3'd6, v); chk(v == 32'h0000_0345, "R1", "base width", int'(v), 32'h345);
        wr(3'd6, 32'(BASE));
        wr(3'd5, {16'd32, 16'd32});

        // R3 launch and busy indications, one fill
        wr(3'd4, 32'h0000_00E1);
        wr(3'd1, {16'd4, 16'd2});
        wr(3'd2, {16'd5, 16'd2});
        wr(3'd3, ctl(1, 1'b0));
        rd(3'd7, v);
        chk(busy == 1'b1 && v[3] == 1'b1, "R3", "busy after launch", int'(v), 8);
        rd(3'd3, v);
        chk(v[31] == 1'b1, "R3", "control bit 31 while busy", int'(v[31]), 1);
        wait_idle();
        rd(3'd3, v);
        chk(v == (ctl(1, 1'b0) & 32'h7FFF_FFFF), "R3", "control after completion", int'(v),
            int'(ctl(1, 1'b0) & 32'h7FFF_FFFF));
        rd(3'd7, v);
        chk(v == 32'h0, "R3", "status after completion", int'(v), 0);
        for (int r = 0; r < 2; r++)
            for (int c = 0; c < 5; c++)
                expm[fa(32, 4 + c, 2 + r)] = 8'hE1;
        check_mem("R2 R4 first fill");

        // R4 R6 fill sweep over sizes in both directions
        for (int rv = 0; rv < 2; rv++)
            for (int w = 1; w <= 4; w++)
                for (int h = 1; h <= 3; h++)
                    do_fill(1 + 5 * w, 5 + 4 * h + rv, w, h, rv[0], 8'(8'h40 + 16 * w + h + 64 * rv));

        // R8 control write while busy
        w0 = nwr;
        wr(3'd4, 32'h5A);
        wr(3'd1, {16'd0, 16'd20});
        wr(3'd2, {16'd8, 16'd4});
        wr(3'd3, ctl(1, 1'b0));
        wr(3'd3, 32'h8002_1111);
        rd(3'd3, v);
        chk(v == ctl(1, 1'b0), "R8", "control unchanged while busy", int'(v), int'(ctl(1, 1'b0)));
        wait_idle();
        repeat (5) @(negedge clk);
        chk(busy == 1'b0 && (nwr - w0) == 32, "R8", "no restart", nwr - w0, 32);
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 8; c++)
                expm[fa(32, c, 20 + r)] = 8'h5A;
        check_mem("R8 fill result");

        // R9 empty and unknown launches
        w0 = nwr; r0 = nrd;
        wr(3'd2, {16'd0, 16'd3}); wr(3'd3, ctl(1, 1'b0)); wait_idle();
        wr(3'd2, {16'd3, 16'd0}); wr(3'd3, ctl(0, 1'b0)); wait_idle();
        wr(3'd2, {16'd3, 16'd3}); wr(3'd3, ctl(2, 1'b0)); wait_idle();
        chk((nwr - w0) + (nrd - r0) == 0 && !busy, "R9", "no memory access", (nwr - w0) + (nrd - r0), 0);
        check_mem("R9 memory untouched");

        // R2 distinct source and destination pitches
        do_copy(2, 1, 9, 3, 4, 3, 24, 32, "R2 pitch copy");

        // R7 overlap sweep
        for (int dy = -2; dy <= 2; dy++)
            for (int dx = -2; dx <= 2; dx++)
                do_copy(12, 12, 12 + dx, 12 + dy, 3, 3, 32, 32, "R7 R10 overlap copy");

        summary();
        $finish;
    end
endmodule